// File: doc/BRIEF.md
# Split-Access 64-bit Microsecond Timebase

This block keeps a 64-bit count of microseconds since reset and makes it reachable through a 32-bit register port. The port has an APB-style handshake: a setup cycle, then an access cycle, and no wait states. Software cannot read or write 64 bits in one access, so the two halves go through staging registers. A write to the low half is held back until the high half is written, and then both halves load at once. A read of the low half records the matching high half, so a later read of the high half returns a value that belongs with it, even if the count carried into the high half between the two reads. Two raw read registers return the live halves and leave the recorded high half alone.

Counting advances once on each cycle in which the 1 µs tick-enable input is high. It can be frozen by a software pause bit. It can also be frozen by either of two processor debug-halt inputs, each gated by its own enable bit. The low 32 bits of the count are driven out continuously so that an alarm comparator elsewhere can use them.

Top module: `usec_timebase`

## Requirements
- R1: After reset the count is zero, the pause register (offset 0x30, bit 0) reads 0, and the debug-enable register (offset 0x2C) reads 0x6, because both enable bits reset to 1.
- R2: The count increases by exactly one at each clock edge where tick_i is high and no freeze condition is active, and holds when tick_i is low.
- R3: A write to offset 0x04 only stages its data and does not change the count. A write to offset 0x00 loads the count with {write data, staged low word}. A load takes priority over an increment in the same cycle.
- R4: A read of offset 0x0C returns the live low word and records the live high word. A read of offset 0x08 returns the most recently recorded high word.
- R5: Offset 0x24 returns the live high word and offset 0x28 returns the live low word. Neither read changes the recorded high word.
- R6: While pause bit 0 at offset 0x30 is 1, the count does not advance.
- R7: At offset 0x2C, bit 1 enables the freeze for dbg_halt_i[0] and bit 2 enables it for dbg_halt_i[1]. The count freezes while any enabled halt input is high. A halt input whose enable bit is clear has no effect.
- R8: Reads of any offset other than 0x08, 0x0C, 0x24, 0x28, 0x2C and 0x30 return zero, including the write-only offsets 0x00 and 0x04. Writes to 0x08, 0x0C, 0x24, 0x28 or unmapped offsets change no state.
- R9: time_lo_o always equals the low 32 bits of the count.
- R10: If the count carries from the low word into the high word between a read of 0x0C and a read of 0x08, the two reads still return the high and low words of the count as it was at the 0x0C read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable that occurs once per microsecond |
| dbg_halt_i | input | 2 | Debug-halt state of processor 0 (bit 0) and processor 1 (bit 1) |
| reg_sel_i | input | 1 | Register port select |
| reg_en_i | input | 1 | Access phase; the access takes effect when this and reg_sel_i are both high |
| reg_we_i | input | 1 | 1 for a write, 0 for a read |
| reg_addr_i | input | 8 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid during the access phase |
| time_lo_o | output | 32 | Low 32 bits of the live count |

## Verification
Directed sequences cover the following. Each freeze source is applied alone with the tick running, which shows the pause bit and each debug gate acting independently. A halt input is held high while its enable bit is cleared, which shows the gating works. A count loaded two steps below a 32-bit carry exposes the difference between the recorded high word and the live high word. Staged-only writes, writes to read-only offsets and reads of unmapped offsets show that no state moves where none should. A seeded random mix of accesses, tick patterns and halt patterns is then checked read by read against a bench model. This mix catches load-versus-increment priority errors and recording errors that the directed cases do not reach.

// File: rtl/utb_pkg.sv
package utb_pkg;
  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_WR_HI  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_WR_LO  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_RD_HI  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_RD_LO  = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_RAW_HI = 8'h24;
  localparam logic [REG_AW-1:0] OFS_RAW_LO = 8'h28;
  localparam logic [REG_AW-1:0] OFS_DBG_EN = 8'h2C;
  localparam logic [REG_AW-1:0] OFS_PAUSE  = 8'h30;

  typedef struct packed {
    logic wr_hi;
    logic wr_lo;
    logic rd_lo;
    logic wr_dbg;
    logic wr_pause;
  } acc_dec_t;
endpackage

// File: rtl/utb_counter.sv
module utb_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;  // load wins over tick
    else if (inc_i) cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/utb_stall.sv
module utb_stall #(
  parameter int unsigned N_DBG = 2
) (
  input  logic             tick_i,
  input  logic             pause_i,
  input  logic [N_DBG-1:0] dbg_en_i,
  input  logic [N_DBG-1:0] dbg_halt_i,
  output logic             inc_o
);
  logic [N_DBG-1:0] halt_hit;

  for (genvar g = 0; g < N_DBG; g++) begin : g_core
    assign halt_hit[g] = dbg_en_i[g] & dbg_halt_i[g];
  end

  assign inc_o = tick_i & ~pause_i & ~(|halt_hit);
endmodule

// File: rtl/utb_regs.sv
module utb_regs
  import utb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_DBG  = 2,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              pause_o,
  output logic [N_DBG-1:0]  dbg_en_o
);
  acc_dec_t         dec;
  logic [DATA_W-1:0] stage_q, hi_lat_q;
  logic              pause_q;
  logic [N_DBG-1:0]  dbg_en_q;
  logic              unused_wdata;

  always_comb begin
    dec          = '0;
    dec.wr_hi    = acc_i &  we_i & (addr_i == OFS_WR_HI);
    dec.wr_lo    = acc_i &  we_i & (addr_i == OFS_WR_LO);
    dec.rd_lo    = acc_i & ~we_i & (addr_i == OFS_RD_LO);
    dec.wr_dbg   = acc_i &  we_i & (addr_i == OFS_DBG_EN);
    dec.wr_pause = acc_i &  we_i & (addr_i == OFS_PAUSE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '0;
      hi_lat_q <= '0;
      pause_q  <= 1'b0;
      dbg_en_q <= '1;
    end else begin
      if (dec.wr_lo)    stage_q  <= wdata_i;
      if (dec.rd_lo)    hi_lat_q <= cnt_i[CNT_W-1:DATA_W];
      if (dec.wr_pause) pause_q  <= wdata_i[0];
      if (dec.wr_dbg)   dbg_en_q <= wdata_i[N_DBG:1];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_RD_HI:  rdata_o = hi_lat_q;
      OFS_RD_LO,
      OFS_RAW_LO: rdata_o = cnt_i[DATA_W-1:0];
      OFS_RAW_HI: rdata_o = cnt_i[CNT_W-1:DATA_W];
      OFS_DBG_EN: rdata_o[N_DBG:1] = dbg_en_q;
      OFS_PAUSE:  rdata_o[0] = pause_q;
      default:    rdata_o = '0;
    endcase
  end

  assign load_o       = dec.wr_hi;
  assign load_val_o   = {wdata_i, stage_q};
  assign pause_o      = pause_q;
  assign dbg_en_o     = dbg_en_q;
  assign unused_wdata = ^wdata_i[DATA_W-1:N_DBG+1];
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import utb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_DBG  = 2,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [N_DBG-1:0]  dbg_halt_i,
  input  logic              reg_sel_i,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [DATA_W-1:0] time_lo_o
);
  logic             acc;
  logic             load, inc, pause_q;
  logic [CNT_W-1:0] load_val, cnt_q;
  logic [N_DBG-1:0] dbg_en_q;

  assign acc = reg_sel_i & reg_en_i;

  utb_regs #(.DATA_W(DATA_W), .N_DBG(N_DBG)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .cnt_i      (cnt_q),
    .load_o     (load),
    .load_val_o (load_val),
    .pause_o    (pause_q),
    .dbg_en_o   (dbg_en_q)
  );

  utb_stall #(.N_DBG(N_DBG)) i_stall (
    .tick_i     (tick_i),
    .pause_i    (pause_q),
    .dbg_en_i   (dbg_en_q),
    .dbg_halt_i (dbg_halt_i),
    .inc_o      (inc)
  );

  utb_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .inc_i      (inc),
    .cnt_o      (cnt_q)
  );

  assign time_lo_o = cnt_q[DATA_W-1:0];
endmodule

// File: rtl/utb_checker.sv
module utb_checker
  import utb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_DBG  = 2,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [N_DBG-1:0]  dbg_halt_i,
  input logic              reg_sel_i,
  input logic              reg_en_i,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              pause_q,
  input logic [N_DBG-1:0]  dbg_en_q,
  input logic [CNT_W-1:0]  load_val
);
  logic past_ok, acc, frz, ld, mapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign acc    = reg_sel_i & reg_en_i;
  assign frz    = pause_q | (|(dbg_en_q & dbg_halt_i));
  assign ld     = acc & reg_we_i & (reg_addr_i == OFS_WR_HI);
  assign mapped = (reg_addr_i == OFS_RD_HI)  || (reg_addr_i == OFS_RD_LO)  ||
                  (reg_addr_i == OFS_RAW_HI) || (reg_addr_i == OFS_RAW_LO) ||
                  (reg_addr_i == OFS_DBG_EN) || (reg_addr_i == OFS_PAUSE);

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && tick_i && !frz && !ld |=> cnt_q == $past(cnt_q) + 1);

  p_freeze_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && (!tick_i || frz) && !ld |=> $stable(cnt_q));

  p_load_both_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ld |=> cnt_q[CNT_W-1:DATA_W] == $past(reg_wdata_i));

  p_stage_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ld |=> cnt_q == $past(load_val));

  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !reg_we_i && !mapped |-> reg_rdata_o == '0);

  p_raw_live_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !reg_we_i && reg_addr_i == OFS_RAW_HI |-> reg_rdata_o == cnt_q[CNT_W-1:DATA_W]);
endmodule

bind usec_timebase utb_checker #(.DATA_W(DATA_W), .N_DBG(N_DBG)) i_utb_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .dbg_halt_i  (dbg_halt_i),
  .reg_sel_i   (reg_sel_i),
  .reg_en_i    (reg_en_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .cnt_q       (cnt_q),
  .pause_q     (pause_q),
  .dbg_en_q    (dbg_en_q),
  .load_val    (load_val)
);

// File: tb/test_usec_timebase.sv
module test_usec_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  halt = 2'b00;
  logic        sel = 1'b0, en = 1'b0, we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, tlo;

  int errors = 0;
  int checks = 0;
  int tick_mode = 0;  // 0 off, 1 on, 2 random

  // reference model state
  logic [63:0] m_cnt;
  logic [31:0] m_stage, m_hi;
  logic        m_pause;
  logic [1:0]  m_dbg;

  always #5 clk = ~clk;

  usec_timebase i_usec_timebase (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .dbg_halt_i(halt),
    .reg_sel_i(sel), .reg_en_i(en), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .time_lo_o(tlo)
  );

  always @(negedge clk) begin
    if (tick_mode == 0)      tick <= 1'b0;
    else if (tick_mode == 1) tick <= 1'b1;
    else                     tick <= ($urandom % 3) != 0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_stage <= '0; m_hi <= '0; m_pause <= 1'b0; m_dbg <= 2'b11;
    end else begin
      if (sel && en && we && addr == 8'h00) m_cnt <= {wdata, m_stage};
      else if (tick && !m_pause && !(|(m_dbg & halt))) m_cnt <= m_cnt + 64'd1;
      if (sel && en && we && addr == 8'h04) m_stage <= wdata;
      if (sel && en && !we && addr == 8'h0C) m_hi <= m_cnt[63:32];
      if (sel && en && we && addr == 8'h30) m_pause <= wdata[0];
      if (sel && en && we && addr == 8'h2C) m_dbg <= wdata[2:1];
    end
  end

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h08:   return m_hi;
      8'h0C:   return m_cnt[31:0];
      8'h24:   return m_cnt[63:32];
      8'h28:   return m_cnt[31:0];
      8'h2C:   return {29'd0, m_dbg, 1'b0};
      8'h30:   return {31'd0, m_pause};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the access edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    sel = 1'b1; en = 1'b0; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); en = 1'b1;
    @(negedge clk); sel = 1'b0; en = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input string tag, output logic [31:0] d);
    sel = 1'b1; en = 1'b0; we = 1'b0; addr = a;
    @(negedge clk); en = 1'b1;
    #1;
    d = rdata;
    check(tag, {32'd0, rdata}, {32'd0, exp_read(a)});
    check("R9 time_lo_o", {32'd0, tlo}, {32'd0, m_cnt[31:0]});
    @(negedge clk); sel = 1'b0; en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] a, b, v;
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset values
    bus_rd(8'h24, "R1 raw hi", v);   check("R1 raw hi zero", {32'd0, v}, 64'd0);
    bus_rd(8'h28, "R1 raw lo", v);   check("R1 raw lo zero", {32'd0, v}, 64'd0);
    bus_rd(8'h2C, "R1 dbg en", v);   check("R1 dbg en 0x6", {32'd0, v}, 64'd6);
    bus_rd(8'h30, "R1 pause", v);    check("R1 pause 0", {32'd0, v}, 64'd0);

    // R2 counting
    tick_mode = 1;
    bus_rd(8'h28, "R2 lo", a);
    bus_rd(8'h28, "R2 lo", b);
    check("R2 two cycles per read", {32'd0, b - a}, 64'd2);
    tick_mode = 0; idle(2);
    bus_rd(8'h28, "R2 hold", a); idle(4);
    bus_rd(8'h28, "R2 hold", b);
    check("R2 no tick holds", {32'd0, b}, {32'd0, a});

    // R3 staged write
    bus_wr(8'h04, 32'hFFFF_FFFE);
    bus_rd(8'h28, "R3 lo unchanged", v);
    check("R3 stage no effect", {32'd0, v}, {32'd0, a});
    tick_mode = 1;
    bus_wr(8'h00, 32'h0000_0005);  // load wins over tick at the access edge

    // R4 / R10 carry between low and high reads
    bus_rd(8'h0C, "R4 lo read", v);
    check("R10 lo before carry", {32'd0, v}, 64'hFFFF_FFFF);
    tick_mode = 0;
    bus_rd(8'h24, "R5 raw hi after carry", v);
    check("R10 live hi carried", {32'd0, v}, 64'd6);
    bus_rd(8'h28, "R5 raw lo", v);
    bus_rd(8'h08, "R4 latched hi", v);
    check("R10 latched hi kept", {32'd0, v}, 64'd5);

    // R8 writes to read-only and unmapped offsets
    bus_wr(8'h24, 32'h1234_5678);
    bus_wr(8'h08, 32'hAAAA_AAAA);
    bus_wr(8'h10, 32'h5555_5555);
    bus_rd(8'h24, "R8 raw hi unchanged", v);
    check("R8 ro write ignored", {32'd0, v}, 64'd6);
    bus_rd(8'h08, "R8 latch unchanged", v);
    check("R8 latch write ignored", {32'd0, v}, 64'd5);
    bus_rd(8'h10, "R8 unmapped", v);
    bus_rd(8'h00, "R8 write-only reads 0", v);
    bus_rd(8'h34, "R8 unmapped", v);

    // R6 pause
    tick_mode = 1;
    bus_wr(8'h30, 32'h1);
    bus_rd(8'h28, "R6 paused", a); idle(5);
    bus_rd(8'h28, "R6 paused", b);
    check("R6 pause freezes", {32'd0, b}, {32'd0, a});
    bus_wr(8'h30, 32'h0);

    // R7 debug gating
    halt = 2'b01; idle(1);
    bus_rd(8'h28, "R7 halt0", a); idle(3);
    bus_rd(8'h28, "R7 halt0", b);
    check("R7 halt0 freezes", {32'd0, b}, {32'd0, a});
    bus_wr(8'h2C, 32'h4);
    bus_rd(8'h28, "R7 halt0 masked", a);
    bus_rd(8'h28, "R7 halt0 masked", b);
    check("R7 masked halt ignored", {32'd0, b - a}, 64'd2);
    halt = 2'b10; idle(1);
    bus_rd(8'h28, "R7 halt1", a); idle(3);
    bus_rd(8'h28, "R7 halt1", b);
    check("R7 halt1 freezes", {32'd0, b}, {32'd0, a});
    halt = 2'b00;
    bus_wr(8'h2C, 32'h6);

    // random mix against the model (R2..R8)
    tick_mode = 2;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ra;
      case ($urandom % 11)
        0: ra = 8'h00; 1: ra = 8'h04; 2: ra = 8'h08; 3: ra = 8'h0C;
        4: ra = 8'h24; 5: ra = 8'h28; 6: ra = 8'h2C; 7: ra = 8'h30;
        8: ra = 8'h10; 9: ra = 8'h0C; default: ra = 8'h28;
      endcase
      if ($urandom % 8 == 0) halt = 2'($urandom);
      if (($urandom % 3 == 0) && ra != 8'h30) begin
        bus_wr(ra, (ra == 8'h04) ? 32'hFFFF_FFF0 + ($urandom % 16) : $urandom);
      end else begin
        bus_rd(ra, "R4 random read", v);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule